// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel characters. It works from a clock-enable pulse that arrives sixteen times per bit period, and it divides each bit into sixteen sub-ticks. A frame starts on a falling edge while the line is idle. Each bit, including the start and stop bits, is read three times near its middle, and the value is the majority of those three reads. The bit timing is pulled back into step on each trustworthy falling edge inside the frame, so a transmitter whose bit rate differs from the receiver's by several percent is still received correctly.

One mode input selects characters of 8 or 9 data bits. The receiver reads this input when a frame starts. Each finished character comes out on a data bus with a one-cycle strobe. It carries two flags: one says that some vote was not unanimous, and one says that the stop bit read low. The bit-rate tick, any buffering and any parity handling belong to the surrounding logic.

Top module: `uart_rx_os`

## Requirements
- R1: While reset is held, and before the first character, `valid_o`, `noise_o`, `ferr_o` and `data_o` are all zero.
- R2: When the line goes from high to low while the receiver is idle, a frame begins, and that tick counts as sub-tick 1 of the start bit. If the vote over sub-ticks 8, 9 and 10 of the start bit reads high, the frame is dropped with no strobe, and the next falling edge is accepted as a new start.
- R3: Each bit is the majority of the line at sub-ticks 8, 9 and 10 of its period. Data bits arrive least significant first. With `len9_i`=0 the character is 8 bits on `data_o[7:0]` and `data_o[8]` is 0. With `len9_i`=1 it is 9 bits, and the last data bit before the stop bit lands in `data_o[8]`. `len9_i` is read at the start edge.
- R4: `noise_o` is 1 for a character when any of its start, data or stop votes had samples that disagree. Otherwise it is 0.
- R5: When the stop vote reads low, `ferr_o` is 1 and the data is still delivered with a strobe. When it reads high, `ferr_o` is 0.
- R6: `valid_o` is high for exactly one clock per character. `data_o`, `noise_o` and `ferr_o` change only in a cycle in which `valid_o` is high.
- R7: A falling edge inside a frame, when the most recent vote was 1, restarts the sub-tick count: the edge becomes sub-tick 1 of the next bit. Alternating data sent with bit periods of 14 or 18 ticks is received without error.
- R8: A falling edge inside a frame that follows a vote of 0 does not move the bit timing. A one-tick high glitch at sub-tick 9 of a low data bit gives the correct data with `noise_o`=1.
- R9: The stop bit is sampled 151 ticks (8-bit) or 167 ticks (9-bit) after the start edge. If the stop bit begins 7 ticks late, the character is clean. If it begins 8 ticks late, `noise_o`=1 and `ferr_o`=0. If it begins 9 ticks late, `noise_o`=1 and `ferr_o`=1.
- R10: A stop bit lasting only 10 ticks, followed at once by the next start bit, gives two correct characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Clock enable, one pulse per sub-tick (16 per bit) |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| len9_i | input | 1 | Character length: 0 = 8 bits, 1 = 9 bits |
| data_o | output | 9 | Last received character |
| valid_o | output | 1 | One-cycle strobe for a new character |
| noise_o | output | 1 | A vote in the last character was not unanimous |
| ferr_o | output | 1 | The stop bit of the last character read low |

## Verification
Random characters at the nominal bit period, in both lengths and with random idle gaps, show that the basic vote and bit order are right. Alternating data sent 12% slow and 12% fast can only be received if the edge realignment works. The same timing without realignment fails. A stop bit that starts 7, 8 and 9 ticks late marks the three outcomes: clean, noisy, and framing error. A high glitch inside a low bit and a low glitch inside the stop bit show that noise is flagged and that edges after a 0 vote leave the timing alone. A short pulse at the start tests false-start rejection, and a 10-tick stop bit followed at once by the next frame tests back-to-back reception.

// File: rtl/uart_rx_os_pkg.sv
package uart_rx_os_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic din_i,
    output logic dout_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d    = sh_q;
        sh_d[0] = din_i;
        for (int i = 1; i < STAGES; i++) begin
            sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) sh_q <= {STAGES{RESET_VAL}};
        else         sh_q <= sh_d;
    end

    assign dout_o = sh_q[STAGES-1];
endmodule

// File: rtl/rx_vote3.sv
module rx_vote3 (
    input  logic s0_i,
    input  logic s1_i,
    input  logic s2_i,
    output logic maj_o,
    output logic split_o
);
    assign maj_o   = (s0_i & s1_i) | (s0_i & s2_i) | (s1_i & s2_i);
    assign split_o = (s0_i ^ s1_i) | (s1_i ^ s2_i);
endmodule

// File: rtl/uart_rx_os.sv
module uart_rx_os
    import uart_rx_os_pkg::*;
#(
    parameter int DATA_MAX    = 9,
    parameter int SUB         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                tick_i,
    input  logic                rxd_i,
    input  logic                len9_i,
    output logic [DATA_MAX-1:0] data_o,
    output logic                valid_o,
    output logic                noise_o,
    output logic                ferr_o
);
    localparam int PH_W = $clog2(SUB);
    localparam int CNT_W = $clog2(DATA_MAX);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SUB - 1);
    localparam logic [PH_W-1:0] PH_ONE = PH_W'(1);
    localparam logic [PH_W-1:0] SMP_A = PH_W'(SUB / 2 - 1);
    localparam logic [PH_W-1:0] SMP_B = PH_W'(SUB / 2);
    localparam logic [PH_W-1:0] SMP_C = PH_W'(SUB / 2 + 1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_LONG = CNT_W'(DATA_MAX - 1);
    localparam logic [CNT_W-1:0] CNT_SHORT = CNT_W'(DATA_MAX - 2);

    typedef struct packed {
        rx_state_e           state;
        logic [PH_W-1:0]     phase;
        logic [CNT_W-1:0]    cnt;
        logic [1:0]          samp;
        logic                decided;
        logic                last_one;
        logic                prev;
        logic                long_mode;
        logic                noise_acc;
        logic [DATA_MAX-1:0] shreg;
        logic [DATA_MAX-1:0] data_out;
        logic                valid;
        logic                noise_out;
        logic                ferr_out;
    } rx_regs_t;

    rx_regs_t r_d, r_q;

    logic            line_w;
    logic            fall_w;
    logic            resync_w;
    logic            advance_w;
    logic [PH_W-1:0] cur_w;
    logic [PH_W-1:0] nxt_w;
    logic            maj_w;
    logic            split_w;

    rx_line_sync #(
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(1'b1)
    ) i_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .din_i (rxd_i),
        .dout_o(line_w)
    );

    rx_vote3 i_vote (
        .s0_i   (r_q.samp[0]),
        .s1_i   (r_q.samp[1]),
        .s2_i   (line_w),
        .maj_o  (maj_w),
        .split_o(split_w)
    );

    assign fall_w    = tick_i & r_q.prev & ~line_w;
    assign cur_w     = (r_q.phase == PH_LAST) ? '0 : r_q.phase + PH_ONE;
    assign resync_w  = fall_w & r_q.last_one & (r_q.state != RX_IDLE);
    assign nxt_w     = resync_w ? '0 : cur_w;
    assign advance_w = resync_w ? r_q.decided : (cur_w == '0);

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        if (tick_i) begin
            r_d.prev = line_w;
            if (r_q.state == RX_IDLE) begin
                if (fall_w) begin
                    r_d.state     = RX_START;
                    r_d.phase     = '0;
                    r_d.cnt       = '0;
                    r_d.decided   = 1'b0;
                    r_d.last_one  = 1'b0;
                    r_d.noise_acc = 1'b0;
                    r_d.shreg     = '0;
                    r_d.long_mode = len9_i;
                end
            end else begin
                r_d.phase = nxt_w;
                if (advance_w) begin
                    r_d.decided = 1'b0;
                    if (r_q.state == RX_START) begin
                        r_d.state = RX_DATA;
                        r_d.cnt   = '0;
                    end else if (r_q.state == RX_DATA) begin
                        if (r_q.cnt == (r_q.long_mode ? CNT_LONG : CNT_SHORT)) begin
                            r_d.state = RX_STOP;
                        end else begin
                            r_d.cnt = r_q.cnt + CNT_ONE;
                        end
                    end
                end else begin
                    if (nxt_w == SMP_A) r_d.samp[0] = line_w;
                    if (nxt_w == SMP_B) r_d.samp[1] = line_w;
                    if (nxt_w == SMP_C) begin
                        r_d.decided   = 1'b1;
                        r_d.noise_acc = r_q.noise_acc | split_w;
                        case (r_q.state)
                            RX_START: begin
                                if (maj_w) r_d.state = RX_IDLE;
                                r_d.last_one = 1'b0;
                            end
                            RX_DATA: begin
                                r_d.shreg[r_q.cnt] = maj_w;
                                r_d.last_one       = maj_w;
                            end
                            RX_STOP: begin
                                r_d.valid     = 1'b1;
                                r_d.data_out  = r_q.shreg;
                                r_d.noise_out = r_q.noise_acc | split_w;
                                r_d.ferr_out  = ~maj_w;
                                r_d.state     = RX_IDLE;
                            end
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q       <= '0;
            r_q.state <= RX_IDLE;
            r_q.prev  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign data_o  = r_q.data_out;
    assign valid_o = r_q.valid;
    assign noise_o = r_q.noise_out;
    assign ferr_o  = r_q.ferr_out;

    // R6: strobe lasts one cycle
    p_strobe_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    // R6: character outputs change only with the strobe
    p_out_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> ($stable(data_o) && $stable(noise_o) && $stable(ferr_o)));

    // R5: a framing error appears only together with a strobe
    p_ferr_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ferr_o) |-> valid_o);

    // R2: a falling edge while idle opens a frame
    p_start_open_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == RX_IDLE && fall_w) |=> (r_q.state == RX_START));

    // R2: a start bit that votes high is dropped
    p_false_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && r_q.state == RX_START && nxt_w == SMP_C && maj_w) |=> (r_q.state == RX_IDLE));

    // R7: a trusted falling edge restarts the sub-tick count
    p_resync_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fall_w && r_q.last_one && r_q.state != RX_IDLE) |=> (r_q.phase == '0));

    // R8: after a low vote, the sub-tick count only steps forward
    p_no_resync_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && r_q.state != RX_IDLE && !r_q.last_one && r_q.phase != PH_LAST)
        |=> (r_q.phase == $past(r_q.phase) + PH_ONE));

    // R7: no timing movement without a tick
    p_hold_no_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> ($stable(r_q.phase) && $stable(r_q.state)));

    // R3: bit counter stays inside the character
    p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.cnt <= CNT_LONG);
endmodule

// File: tb/test_uart_rx_os.sv
module test_uart_rx_os;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic       len9 = 1'b0;
    logic [8:0] data_o;
    logic       valid_o, noise_o, ferr_o;

    int n_checks = 0;
    int n_fail = 0;
    int seen = 0;
    int double_pulse = 0;
    logic [8:0] cap_data = '0, prev_cap_data = '0;
    logic cap_noise = 1'b0, cap_ferr = 1'b0, last_valid = 1'b0;
    int div = 0;

    uart_rx_os i_uart_rx_os (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .tick_i (tick),
        .rxd_i  (rxd),
        .len9_i (len9),
        .data_o (data_o),
        .valid_o(valid_o),
        .noise_o(noise_o),
        .ferr_o (ferr_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            div  <= 0;
            tick <= 1'b0;
        end else begin
            div  <= (div == TICK_DIV - 1) ? 0 : div + 1;
            tick <= (div == TICK_DIV - 1);
        end
    end

    always @(negedge clk) begin
        if (valid_o && last_valid) double_pulse++;
        last_valid = valid_o;
        if (valid_o) begin
            seen++;
            prev_cap_data = cap_data;
            cap_data = data_o;
            cap_noise = noise_o;
            cap_ferr = ferr_o;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) begin
            do @(negedge clk); while (!tick);
        end
    endtask

    task automatic line_for(input logic v, input int n);
        rxd = v;
        wait_ticks(n);
    endtask

    function automatic logic [8:0] exp_data(input logic [8:0] d, input int nb);
        return (nb == 9) ? d : {1'b0, d[7:0]};
    endfunction

    task automatic send_frame(input logic [8:0] d, input int nb, input int per,
                              input int last_len, input logic stop_v, input int stop_len);
        line_for(1'b0, per);
        for (int i = 0; i < nb; i++) begin
            line_for(d[i], (i == nb - 1) ? last_len : per);
        end
        line_for(stop_v, stop_len);
    endtask

    task automatic expect_frame(input string tag, input int base, input logic [8:0] d,
                                input logic nz, input logic fe);
        chk(seen == base + 1, {tag, " strobe count"}, seen - base, 1);
        chk(cap_data == d, {tag, " data"}, int'(cap_data), int'(d));
        chk(cap_noise == nz, {tag, " noise"}, int'(cap_noise), int'(nz));
        chk(cap_ferr == fe, {tag, " framing"}, int'(cap_ferr), int'(fe));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int base;
        logic [8:0] d;
        int nb;
        int rnd;
        rnd = $urandom(32'h5eed);

        // R1: reset state
        repeat (6) @(negedge clk);
        chk(!valid_o && !noise_o && !ferr_o && data_o == 0, "R1 outputs in reset",
            {valid_o, noise_o, ferr_o, data_o}, 0);
        rst_n = 1'b1;
        wait_ticks(20);
        chk(!valid_o && !noise_o && !ferr_o && data_o == 0, "R1 outputs idle",
            {valid_o, noise_o, ferr_o, data_o}, 0);

        // R3: plain 8-bit and 9-bit characters
        len9 = 1'b0; base = seen;
        send_frame(9'h0A5, 8, 16, 16, 1'b1, 16); line_for(1'b1, 20);
        expect_frame("R3 8-bit", base, 9'h0A5, 1'b0, 1'b0);
        len9 = 1'b1; base = seen;
        send_frame(9'h1C3, 9, 16, 16, 1'b1, 16); line_for(1'b1, 20);
        expect_frame("R3 9-bit", base, 9'h1C3, 1'b0, 1'b0);
        len9 = 1'b0;

        // R2: false start then a good frame
        base = seen;
        line_for(1'b0, 5); line_for(1'b1, 30);
        chk(seen == base, "R2 false start strobe", seen - base, 0);
        send_frame(9'h03C, 8, 16, 16, 1'b1, 16); line_for(1'b1, 20);
        expect_frame("R2 after false start", base, 9'h03C, 1'b0, 1'b0);

        // R5: stop bit low
        base = seen;
        send_frame(9'h05A, 8, 16, 16, 1'b0, 16); line_for(1'b1, 20);
        expect_frame("R5 framing error", base, 9'h05A, 1'b0, 1'b1);

        // R4 R8: high glitch at sub-tick 9 of low bit 3
        base = seen;
        line_for(1'b0, 16);
        for (int i = 0; i < 8; i++) begin
            if (i == 3) begin
                line_for(1'b0, 8); line_for(1'b1, 1); line_for(1'b0, 7);
            end else begin
                line_for(1'b0, 16);
            end
        end
        line_for(1'b1, 16); line_for(1'b1, 20);
        expect_frame("R8 glitch in low bit", base, 9'h000, 1'b1, 1'b0);

        // R4: low glitch at sub-tick 9 of stop bit after a low bit
        base = seen;
        send_frame(9'h000, 8, 16, 16, 1'b1, 8);
        line_for(1'b0, 1); line_for(1'b1, 7); line_for(1'b1, 20);
        expect_frame("R4 stop glitch", base, 9'h000, 1'b1, 1'b0);

        // R7: alternating data, slow and fast transmitter
        base = seen;
        send_frame(9'h055, 8, 18, 18, 1'b1, 18); line_for(1'b1, 20);
        expect_frame("R7 slow 18", base, 9'h055, 1'b0, 1'b0);
        base = seen;
        send_frame(9'h055, 8, 14, 14, 1'b1, 14); line_for(1'b1, 20);
        expect_frame("R7 fast 14", base, 9'h055, 1'b0, 1'b0);

        // R9: late stop bit, 7/8/9 ticks late
        base = seen;
        send_frame(9'h07F, 8, 16, 23, 1'b1, 16); line_for(1'b1, 20);
        expect_frame("R9 late 7", base, 9'h07F, 1'b0, 1'b0);
        base = seen;
        send_frame(9'h07F, 8, 16, 24, 1'b1, 16); line_for(1'b1, 20);
        expect_frame("R9 late 8", base, 9'h07F, 1'b1, 1'b0);
        base = seen;
        send_frame(9'h07F, 8, 16, 25, 1'b1, 16); line_for(1'b1, 20);
        expect_frame("R9 late 9", base, 9'h07F, 1'b1, 1'b1);

        // R10: 10-tick stop then next start at once
        base = seen;
        send_frame(9'h03C, 8, 16, 16, 1'b1, 10);
        send_frame(9'h0C3, 8, 16, 16, 1'b1, 16); line_for(1'b1, 20);
        chk(seen == base + 2, "R10 two strobes", seen - base, 2);
        chk(prev_cap_data == 9'h03C, "R10 first data", int'(prev_cap_data), 'h3C);
        chk(cap_data == 9'h0C3 && !cap_noise && !cap_ferr, "R10 second data",
            int'(cap_data), 'hC3);

        // R3 R4 R5: random characters at nominal period
        for (int k = 0; k < 40; k++) begin
            d = 9'($urandom);
            nb = ($urandom % 2 == 0) ? 8 : 9;
            len9 = (nb == 9);
            base = seen;
            send_frame(d, nb, 16, 16, 1'b1, 16);
            line_for(1'b1, 12 + int'($urandom % 20));
            expect_frame("R3 random", base, exp_data(d, nb), 1'b0, 1'b0);
        end

        // R6: no strobe lasted more than one cycle
        chk(double_pulse == 0, "R6 single-cycle strobe", double_pulse, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule